// File: doc/BRIEF.md
# Signed Sequential Booth Multiplier

This block multiplies two signed two's-complement operands of `N` bits (default 8) and returns their full `2N`-bit signed product. It works one multiplier bit per clock, using radix-2 Booth recoding. A working register of `2N+1` bits keeps three things. The top `N` bits hold the running partial sum. The next `N` bits hold the multiplier. The lowest bit holds the multiplier bit that was shifted out in the previous step. On each step the block reads the two lowest bits of the register as a pair and makes one of three choices:

- subtract the captured multiplicand from the partial sum,
- add the multiplicand to the partial sum,
- leave the partial sum unchanged.

After that choice, the whole register shifts right by one place with sign extension.

To start a multiplication, the user presents both operands and raises `start` while the block is idle. The block captures the operands on that edge and raises `busy` for exactly `N` cycles. It then pulses `done` for one cycle. From that point the product stays on `product` until the next accepted start. While `busy` is high, `product` shows intermediate register contents, which are not meaningful.

Top module: `booth_seq_mul`

## Requirements
- R1: During synchronous active-low reset and on the first cycle after it, `product` is 0, `busy` is 0 and `done` is 0.
- R2: If `start` is high at a clock edge while `busy` is low, the operands are captured and `busy` is high from the next cycle on. This also applies in the cycle where `done` is high.
- R3: `busy` stays high for exactly `N` consecutive cycles. `done` is high for exactly one cycle, the first cycle after `busy` falls.
- R4: When `done` is high, `product` equals the signed product of the multiplicand and multiplier captured at the accepted start. This holds for every operand pair.
- R5: `start` and operand values seen while `busy` is high have no effect. The product reported at `done` is that of the operands captured at the accepted start.
- R6: While `busy` is low and no start is accepted, `product` keeps its value.
- R7: The following products are exact:
  - a negative multiplier with a positive multiplicand (2 × -3 = -6);
  - the most negative value times itself (at N=8, -128 × -128 = 16384);
  - the most negative value times the most positive value.

  These rely on the partial sum being formed `N+1` bits wide and on the sign-extending shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiplication; accepted only while idle |
| mcand | input | N | Signed multiplicand, sampled at an accepted start |
| mplier | input | N | Signed multiplier, sampled at an accepted start |
| product | output | 2N | Signed product; valid from `done` until the next accepted start |
| busy | output | 1 | High while the N Booth steps run |
| done | output | 1 | One-cycle pulse when the product is ready |

## Verification
The assertions assume the following about the block's inputs:
- `rst_n` is held low for at least one rising edge before operation.
- `start` and the operands are stable around each rising edge.
- The operands matter only in the cycle where a start is accepted.

The bench follows these assumptions. It holds reset for three cycles and changes every input only on the falling clock edge. It also deliberately scrambles the operands and pulses `start` while a multiplication is running. This shows that those values fall outside what the block samples.

// File: rtl/booth_mul_pkg.sv
// Package: types shared by the Booth multiplier modules.
// Assumes: nothing; holds only the step-operation encoding.
package booth_mul_pkg;
    typedef enum logic [1:0] {
        BOOTH_SKIP = 2'd0,
        BOOTH_ADD  = 2'd1,
        BOOTH_SUB  = 2'd2
    } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
// booth_recode: turns the (current, right-neighbour) multiplier bit pair
// into a Booth step operation. Pair 10 starts a run of ones (subtract),
// pair 01 ends a run (add), and 00 or 11 lie inside a run (skip).
// Assumes: the right-neighbour bit is 0 before the first step.
module booth_recode
    import booth_mul_pkg::*;
(
    input  logic      cur_bit,
    input  logic      right_bit,
    output booth_op_e op
);
    // Decode the bit pair into an operation.
    always_comb begin
        unique case ({cur_bit, right_bit})
            2'b10:   op = BOOTH_SUB;
            2'b01:   op = BOOTH_ADD;
            default: op = BOOTH_SKIP;
        endcase
    end
endmodule

// File: rtl/booth_step.sv
// booth_step: one radix-2 Booth iteration on the {sum, multiplier, prev}
// register. The sum update is formed N+1 bits wide, so the most negative
// multiplicand cannot overflow. The arithmetic right shift then falls out
// of simply dropping the lowest bit of {wide_sum, low}.
// Assumes: acc holds a partial sum that is representable in N bits.
module booth_step
    import booth_mul_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] acc,
    input  logic [N-1:0] low,
    input  logic [N-1:0] mcand,
    input  booth_op_e    op,
    output logic [2*N:0] nxt
);
    localparam int WW = N + 1;

    logic signed [WW-1:0] acc_w;
    logic signed [WW-1:0] mc_w;
    logic signed [WW-1:0] sum_w;

    // Sign-extend both addends and apply the selected operation.
    always_comb begin
        acc_w = {acc[N-1], acc};
        mc_w  = {mcand[N-1], mcand};
        unique case (op)
            BOOTH_ADD: sum_w = acc_w + mc_w;
            BOOTH_SUB: sum_w = acc_w - mc_w;
            default:   sum_w = acc_w;
        endcase
    end

    // Shift right by one with the wide sum's sign as the new top bit.
    assign nxt = {sum_w, low};
endmodule

// File: rtl/booth_ctrl.sv
// booth_ctrl: sequencing for the multiplier. Accepts start only while
// idle, counts N step cycles, then pulses done for a single cycle.
// Assumes: start is synchronous to clk.
module booth_ctrl #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] cnt_q;

    assign load = start && !busy;
    assign step = busy;

    // Run/idle state, step counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt_q <= '0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (cnt_q == LAST) begin
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (start) begin
                busy  <= 1'b1;
                cnt_q <= '0;
            end
        end
    end
endmodule

// File: rtl/booth_seq_mul.sv
// booth_seq_mul: signed N x N sequential multiplier using radix-2 Booth
// recoding, one multiplier bit per cycle and N cycles per product.
// Assumes: N >= 2; operands are two's complement and sampled at an
// accepted start; product is meaningful only while busy is low.
module booth_seq_mul
    import booth_mul_pkg::*;
#(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [N-1:0]     mcand,
    input  logic [N-1:0]     mplier,
    output logic [2*N-1:0]   product,
    output logic             busy,
    output logic             done
);
    localparam int RW = 2 * N + 1;

    logic [RW-1:0] work_q;
    logic [N-1:0]  mcand_q;
    logic [RW-1:0] work_nxt;
    logic          load;
    logic          step;
    booth_op_e     op;

    booth_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    booth_recode u_recode (
        .cur_bit   (work_q[1]),
        .right_bit (work_q[0]),
        .op        (op)
    );

    booth_step #(.N(N)) u_step (
        .acc   (work_q[RW-1 -: N]),
        .low   (work_q[N:1]),
        .mcand (mcand_q),
        .op    (op),
        .nxt   (work_nxt)
    );

    // Working register: load operands on start, advance one step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q  <= '0;
            mcand_q <= '0;
        end else if (load) begin
            work_q  <= {{N{1'b0}}, mplier, 1'b0};
            mcand_q <= mcand;
        end else if (step) begin
            work_q  <= work_nxt;
        end
    end

    assign product = work_q[RW-1:1];
endmodule

// File: rtl/booth_seq_mul_chk.sv
// booth_seq_mul_chk: protocol checks on the multiplier ports.
// Assumes: reset is held low for at least one edge at power-up.
module booth_seq_mul_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [2*N-1:0] product,
    input logic           busy,
    input logic           done
);
    localparam int RCW = $clog2(N + 2) + 1;
    localparam logic [RCW-1:0] N_L = RCW'(N);

    logic [RCW-1:0] run_q;

    // Count consecutive busy cycles to check the run length.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= busy ? run_q + 1'b1 : '0;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && product == '0));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_q == N_L));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));
endmodule

bind booth_seq_mul booth_seq_mul_chk #(.N(N)) u_booth_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .product (product),
    .busy    (busy),
    .done    (done)
);

// File: tb/booth_seq_mul_bench.sv
// Bench: two instances (N=8 and N=4) checked against a behavioural
// cycle model on every falling edge; 4 ns clock period (250 MHz).
module booth_seq_mul_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;
    logic rst_n = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic s8 = 0;  logic signed [7:0] a8 = 0, b8 = 0;
    logic signed [15:0] p8; logic bz8, dn8;
    logic s4 = 0;  logic signed [3:0] a4 = 0, b4 = 0;
    logic signed [7:0] p4;  logic bz4, dn4;

    booth_seq_mul #(.N(8)) u_booth_seq_mul (
        .clk(clk), .rst_n(rst_n), .start(s8), .mcand(a8), .mplier(b8),
        .product(p8), .busy(bz8), .done(dn8));

    booth_seq_mul #(.N(4)) u_booth_seq_mul_n4 (
        .clk(clk), .rst_n(rst_n), .start(s4), .mcand(a4), .mplier(b4),
        .product(p4), .busy(bz4), .done(dn4));

    task automatic chk(input string tag, input logic signed [31:0] act,
                       input logic signed [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Behavioural reference: start accepted only when idle, N busy cycles.
    logic m8_busy = 0, m8_done = 0; int m8_cnt = 0, m8_a = 0, m8_b = 0, m8_p = 0;
    logic m4_busy = 0, m4_done = 0; int m4_cnt = 0, m4_a = 0, m4_b = 0, m4_p = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m8_busy <= 0; m8_done <= 0; m8_cnt <= 0; m8_p <= 0;
            m4_busy <= 0; m4_done <= 0; m4_cnt <= 0; m4_p <= 0;
        end else begin
            m8_done <= 0;
            if (m8_busy) begin
                if (m8_cnt == 7) begin m8_busy <= 0; m8_done <= 1; m8_p <= m8_a * m8_b; end
                else m8_cnt <= m8_cnt + 1;
            end else if (s8) begin
                m8_busy <= 1; m8_cnt <= 0; m8_a <= int'(a8); m8_b <= int'(b8);
            end
            m4_done <= 0;
            if (m4_busy) begin
                if (m4_cnt == 3) begin m4_busy <= 0; m4_done <= 1; m4_p <= m4_a * m4_b; end
                else m4_cnt <= m4_cnt + 1;
            end else if (s4) begin
                m4_busy <= 1; m4_cnt <= 0; m4_a <= int'(a4); m4_b <= int'(b4);
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 busy n8", bz8, m8_busy);
            chk("R3 done n8", dn8, m8_done);
            if (!m8_busy) chk(m8_done ? "R4 product n8" : "R6 hold n8", p8, m8_p);
            chk("R3 busy n4", bz4, m4_busy);
            chk("R3 done n4", dn4, m4_done);
            if (!m4_busy) chk(m4_done ? "R4 product n4" : "R6 hold n4", p4, m4_p);
        end
    end

    task automatic op8(input int x, input int y, input string tag);
        @(negedge clk); a8 = 8'(x); b8 = 8'(y); s8 = 1;
        @(negedge clk); s8 = 0; a8 = ~a8; b8 = ~b8;
        repeat (8) @(negedge clk);
        chk(tag, p8, x * y);
    endtask

    task automatic op4(input int x, input int y);
        @(negedge clk); a4 = 4'(x); b4 = 4'(y); s4 = 1;
        @(negedge clk); s4 = 0; a4 = ~a4; b4 = ~b4;
        repeat (4) @(negedge clk);
        chk("R4 exhaustive n4", p4, x * y);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk("R1 busy", bz8, 0); chk("R1 done", dn8, 0); chk("R1 product", p8, 0);
        chk("R1 product n4", p4, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle after reset", bz8, 0);

        for (int x = -8; x < 8; x++)
            for (int y = -8; y < 8; y++)
                op4(x, y);

        // R7: sign corner cases
        op8(2, -3, "R7 neg multiplier");
        op8(-128, -128, "R7 min x min");
        op8(-128, 127, "R7 min x max");
        op8(127, -128, "R7 max x min");
        op8(-1, -1, "R7 minus one squared");

        for (int i = 0; i < 300; i++)
            op8($signed(8'($urandom)), $signed(8'($urandom)), "R4 random n8");

        // R5: start and operand changes while busy are ignored
        @(negedge clk); a8 = 8'sd5; b8 = -8'sd7; s8 = 1;
        @(negedge clk); a8 = 8'sd100; b8 = 8'sd99;
        repeat (4) @(negedge clk);
        s8 = 0;
        repeat (4) @(negedge clk);
        chk("R5 ignore start", p8, -35);
        chk("R5 done flag", dn8, 1);

        // R2: start accepted in the done cycle
        a8 = 8'sd9; b8 = 8'sd11; s8 = 1;
        @(negedge clk); s8 = 0;
        chk("R2 busy after start", bz8, 1);
        repeat (8) @(negedge clk);
        chk("R2 back-to-back product", p8, 99);

        // R6: hold over idle cycles
        repeat (5) @(negedge clk);
        chk("R6 idle product", p8, 99);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        summary();
    end
endmodule